// File: doc/BRIEF.md
# Timer Run and External Interrupt Flag Register

This block is an 8-bit control and status register on a special-function-register bus. It holds a run-enable bit and an overflow flag for each of two timers. It also holds a request flag and a trigger-type bit for each of two active-low external interrupt pins. The timers see the run bits on `timer_run`. The interrupt controller sees the overflow flags on `timer_irq_req` and the pin flags on `ext_irq_req`. The controller returns a one-cycle acknowledge strobe when it vectors to a handler.

Each pin flag runs in one of two modes, chosen by its type bit. In edge mode the flag latches on a high-to-low transition of the synchronized pin, and an acknowledge clears it. In level mode the flag mirrors the inverted synchronized pin; it is set while the pin is held low and is not affected by an acknowledge or a software write.

Software reaches the register two ways. A byte access at the register address reads or writes all eight bits. A bit access in the bit-address space reads or writes a single bit through bit 0 of the data. Byte addresses of the neighbouring timer count registers are not decoded by this block.

Top module: `tmrctl_reg`

## Requirements
- R1: After reset the register reads 0x00 and `timer_run`, `timer_irq_req` and `ext_irq_req` are all zero.
- R2: A byte write with `bus_bit_mode`=0 at address 0x88 loads all eight bits, and a byte read there returns them. The bit layout from bit 7 down to bit 0 is: timer-1 overflow flag, timer-1 run, timer-0 overflow flag, timer-0 run, pin-1 flag, pin-1 type, pin-0 flag, pin-0 type.
- R3: With `bus_bit_mode`=1, address 0x88+n (n = 0..7) selects bit n. A write loads `bus_wdata[0]` into that bit only. A read returns that bit on `bus_rdata[0]`, with the upper bits zero.
- R4: Byte accesses at any address other than 0x88 (0x8A, 0x8B, 0x8C and 0x8D included) write nothing. For such an access `bus_hit` is 0 and `bus_rdata` is 0x00.
- R5: A `tmr_ovf` pulse sets that timer's overflow flag in the next cycle. The set wins over a same-cycle acknowledge and over a same-cycle software write of 0.
- R6: A `tmr_ack` strobe with no same-cycle overflow clears that timer's flag in the next cycle and leaves the other timer's flag unchanged.
- R7: `timer_run` shows the two run bits (bit 6 for timer 1, bit 4 for timer 0). Only bus writes change them.
- R8: With type bit = 1 (edge mode), a 1-to-0 transition on `ext_pin_n` sets the pin flag three clock edges after the pin changes. This delay comes from two synchronizer stages and one edge-compare stage. A pin held low or a rising transition does not set the flag again.
- R9: In edge mode an `ext_ack` strobe clears the pin flag, and a falling edge detected in the same cycle wins over the strobe.
- R10: With type bit = 0 (level mode), the pin flag equals the inverted synchronized pin and follows it with the same three-edge delay. An acknowledge or a write to the flag does not change it. The mode used in a cycle is the type value after that cycle's write.
- R11: In edge mode, and for the overflow flags, software can set or clear a flag directly through byte or bit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf | input | 2 | Overflow pulse per timer |
| tmr_ack | input | 2 | Vector acknowledge per timer interrupt |
| ext_pin_n | input | 2 | Raw active-low external interrupt pins |
| ext_ack | input | 2 | Vector acknowledge per external interrupt |
| bus_addr | input | 8 | Byte address or bit address |
| bus_bit_mode | input | 1 | 1 selects the bit-address space |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; bit 0 used for bit writes |
| bus_rdata | output | 8 | Read data for the current address |
| bus_hit | output | 1 | Current address is decoded by this block |
| timer_run | output | 2 | Run enables to the timers |
| timer_irq_req | output | 2 | Timer overflow requests |
| ext_irq_req | output | 2 | External pin requests |

## Verification
The bench builds the block with its default parameters: an 8-bit address, register address 0x88 and two synchronizer stages. With an 8-bit address the neighbouring count-byte addresses 0x8A to 0x8D are reachable, so the decode can be shown to ignore them while the same values in bit mode still hit. Two synchronizer stages fix the pin-to-flag latency at three edges, so the bench can sample the cycle before and the cycle of the flag change. That timing lets it place an acknowledge exactly on the edge-detect cycle.

// File: rtl/tmrctl_pkg.sv
package tmrctl_pkg;

    localparam int NCH   = 2;
    localparam int REG_W = 8;

    typedef struct packed {
        logic [NCH-1:0] tf;   // timer overflow flags
        logic [NCH-1:0] tr;   // timer run enables
        logic [NCH-1:0] ie;   // external pin flags
        logic [NCH-1:0] it;   // external trigger type, 1 = edge
    } ctl_state_t;

    // Bit positions; neighbours decode these, so they are fixed.
    function automatic int unsigned tf_pos(int unsigned ch);
        return (ch == 0) ? 5 : 7;
    endfunction

    function automatic int unsigned tr_pos(int unsigned ch);
        return (ch == 0) ? 4 : 6;
    endfunction

    function automatic int unsigned ie_pos(int unsigned ch);
        return (ch == 0) ? 1 : 3;
    endfunction

    function automatic int unsigned it_pos(int unsigned ch);
        return (ch == 0) ? 0 : 2;
    endfunction

    function automatic logic [REG_W-1:0] to_byte(ctl_state_t s);
        logic [REG_W-1:0] b;
        b = '0;
        for (int unsigned ch = 0; ch < NCH; ch++) begin
            b[tf_pos(ch)] = s.tf[ch];
            b[tr_pos(ch)] = s.tr[ch];
            b[ie_pos(ch)] = s.ie[ch];
            b[it_pos(ch)] = s.it[ch];
        end
        return b;
    endfunction

endpackage

// File: rtl/tmrctl_pin_sync.sv
module tmrctl_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level,
    output logic fall
);

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], pin_n};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;   // idle pin is high; no false edge out of reset
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/tmrctl_bus_dec.sv
module tmrctl_bus_dec #(
    parameter int                ADDR_W   = 8,
    parameter int                REG_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bit_mode,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  cur,
    output logic [REG_W-1:0]  wr_mask,
    output logic [REG_W-1:0]  wr_val,
    output logic [REG_W-1:0]  rdata,
    output logic              hit
);

    localparam int IDX_W = $clog2(REG_W);

    logic             byte_hit;
    logic             bit_hit;
    logic [IDX_W-1:0] bit_idx;

    always_comb begin
        byte_hit = !bit_mode && (addr == REG_ADDR);
        bit_hit  = bit_mode && (addr[ADDR_W-1:IDX_W] == REG_ADDR[ADDR_W-1:IDX_W]);
        bit_idx  = addr[IDX_W-1:0];
        hit      = byte_hit || bit_hit;

        wr_mask = '0;
        if (wr && byte_hit) begin
            wr_mask = '1;
        end else if (wr && bit_hit) begin
            wr_mask[bit_idx] = 1'b1;
        end
        wr_val = byte_hit ? wdata : {REG_W{wdata[0]}};

        rdata = '0;
        if (byte_hit) begin
            rdata = cur;
        end else if (bit_hit) begin
            rdata[0] = cur[bit_idx];
        end
    end

endmodule

// File: rtl/tmrctl_reg.sv
module tmrctl_reg #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h88,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [tmrctl_pkg::NCH-1:0]      tmr_ovf,
    input  logic [tmrctl_pkg::NCH-1:0]      tmr_ack,
    input  logic [tmrctl_pkg::NCH-1:0]      ext_pin_n,
    input  logic [tmrctl_pkg::NCH-1:0]      ext_ack,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_bit_mode,
    input  logic                            bus_wr,
    input  logic [tmrctl_pkg::REG_W-1:0]    bus_wdata,
    output logic [tmrctl_pkg::REG_W-1:0]    bus_rdata,
    output logic                            bus_hit,
    output logic [tmrctl_pkg::NCH-1:0]      timer_run,
    output logic [tmrctl_pkg::NCH-1:0]      timer_irq_req,
    output logic [tmrctl_pkg::NCH-1:0]      ext_irq_req
);

    import tmrctl_pkg::*;

    ctl_state_t       st_d, st_q;
    logic [REG_W-1:0] cur_byte;
    logic [REG_W-1:0] wr_mask;
    logic [REG_W-1:0] wr_val;
    logic [NCH-1:0]   pin_lvl;
    logic [NCH-1:0]   edge_fall;
    logic [NCH-1:0]   ext_type_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_pin
        tmrctl_pin_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (ext_pin_n[ch]),
            .level (pin_lvl[ch]),
            .fall  (edge_fall[ch])
        );
    end

    assign cur_byte = to_byte(st_q);

    tmrctl_bus_dec #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .addr     (bus_addr),
        .bit_mode (bus_bit_mode),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .cur      (cur_byte),
        .wr_mask  (wr_mask),
        .wr_val   (wr_val),
        .rdata    (bus_rdata),
        .hit      (bus_hit)
    );

    always_comb begin
        st_d = st_q;
        for (int unsigned ch = 0; ch < NCH; ch++) begin
            // software-only bits
            if (wr_mask[tr_pos(ch)]) st_d.tr[ch] = wr_val[tr_pos(ch)];
            if (wr_mask[it_pos(ch)]) st_d.it[ch] = wr_val[it_pos(ch)];

            // overflow flag: hardware set > acknowledge > software
            if (tmr_ovf[ch]) begin
                st_d.tf[ch] = 1'b1;
            end else if (tmr_ack[ch]) begin
                st_d.tf[ch] = 1'b0;
            end else if (wr_mask[tf_pos(ch)]) begin
                st_d.tf[ch] = wr_val[tf_pos(ch)];
            end

            // pin flag: mode from the post-write type bit
            if (!st_d.it[ch]) begin
                st_d.ie[ch] = ~pin_lvl[ch];
            end else if (edge_fall[ch]) begin
                st_d.ie[ch] = 1'b1;
            end else if (ext_ack[ch]) begin
                st_d.ie[ch] = 1'b0;
            end else if (wr_mask[ie_pos(ch)]) begin
                st_d.ie[ch] = wr_val[ie_pos(ch)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_type_q    = st_q.it;
    assign timer_run     = st_q.tr;
    assign timer_irq_req = st_q.tf;
    assign ext_irq_req   = st_q.ie;

endmodule

// File: rtl/tmrctl_reg_chk.sv
module tmrctl_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88,
    parameter int                NCH      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    tmr_ovf,
    input logic [NCH-1:0]    tmr_ack,
    input logic [NCH-1:0]    ext_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_bit_mode,
    input logic              bus_wr,
    input logic              bus_hit,
    input logic [NCH-1:0]    timer_run,
    input logic [NCH-1:0]    timer_irq_req,
    input logic [NCH-1:0]    ext_irq_req,
    input logic [NCH-1:0]    ext_type_q,
    input logic [NCH-1:0]    pin_lvl,
    input logic [NCH-1:0]    edge_fall
);

    // R4: neighbour byte addresses are never claimed
    assert_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_bit_mode && bus_addr != REG_ADDR) |-> !bus_hit);

    // R7: run enables only move on a bus write
    assert_run_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(timer_run));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // R5: overflow pulse always lands
        assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[ch] |=> timer_irq_req[ch]);

        // R6: acknowledge clears the overflow flag
        assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_ack[ch] && !tmr_ovf[ch]) |=> !timer_irq_req[ch]);

        // R9: edge-mode acknowledge clears the pin flag
        assert_edge_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_type_q[ch] && !bus_wr && ext_ack[ch] && !edge_fall[ch]) |=> !ext_irq_req[ch]);

        // R10: level-mode flag survives acknowledge while the pin is low
        assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_type_q[ch] && !bus_wr && !pin_lvl[ch]) |=> ext_irq_req[ch]);
    end

endmodule

bind tmrctl_reg tmrctl_reg_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .NCH      (tmrctl_pkg::NCH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tmr_ovf       (tmr_ovf),
    .tmr_ack       (tmr_ack),
    .ext_ack       (ext_ack),
    .bus_addr      (bus_addr),
    .bus_bit_mode  (bus_bit_mode),
    .bus_wr        (bus_wr),
    .bus_hit       (bus_hit),
    .timer_run     (timer_run),
    .timer_irq_req (timer_irq_req),
    .ext_irq_req   (ext_irq_req),
    .ext_type_q    (ext_type_q),
    .pin_lvl       (pin_lvl),
    .edge_fall     (edge_fall)
);

// File: tb/tmrctl_reg_test.sv
module tmrctl_reg_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 10;

    // {bit_mode, addr, wdata, expected byte read at 0x88}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 8'h88, 8'h55, 8'h55},
        {1'b0, 8'h8A, 8'hFF, 8'h55},
        {1'b0, 8'h8C, 8'hFF, 8'h55},
        {1'b1, 8'h8E, 8'h00, 8'h15},
        {1'b1, 8'h8B, 8'h01, 8'h1D},
        {1'b1, 8'h88, 8'h00, 8'h1C},
        {1'b1, 8'h89, 8'h01, 8'h1C},
        {1'b0, 8'h8D, 8'h00, 8'h1C},
        {1'b0, 8'h88, 8'hAA, 8'hA0},
        {1'b0, 8'h88, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tmr_ovf = '0;
    logic [1:0] tmr_ack = '0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] ext_ack = '0;
    logic [7:0] bus_addr = 8'h88;
    logic       bus_bit_mode = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_hit;
    logic [1:0] timer_run;
    logic [1:0] timer_irq_req;
    logic [1:0] ext_irq_req;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmrctl_reg uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tmr_ovf       (tmr_ovf),
        .tmr_ack       (tmr_ack),
        .ext_pin_n     (ext_pin_n),
        .ext_ack       (ext_ack),
        .bus_addr      (bus_addr),
        .bus_bit_mode  (bus_bit_mode),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_hit       (bus_hit),
        .timer_run     (timer_run),
        .timer_irq_req (timer_irq_req),
        .ext_irq_req   (ext_irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic bm, input logic [7:0] a, input logic [7:0] d);
        bus_bit_mode = bm;
        bus_addr     = a;
        bus_wdata    = d;
        bus_wr       = 1'b1;
        tick(1);
        bus_wr       = 1'b0;
        bus_bit_mode = 1'b0;
        bus_addr     = 8'h88;
    endtask

    task automatic read_at(input logic bm, input logic [7:0] a, output logic [7:0] d);
        bus_bit_mode = bm;
        bus_addr     = a;
        #1;
        d = bus_rdata;
        bus_bit_mode = 1'b0;
        bus_addr     = 8'h88;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        read_at(1'b0, 8'h88, rd);
        chk("R1 reg", rd, 8'h00);
        chk("R1 outs", {2'b0, timer_run, timer_irq_req, ext_irq_req}, 8'h00);

        // R2 R3 R4 R10 R11 table walk
        for (int k = 0; k < NVEC; k++) begin
            bus_write(VEC[k][24], VEC[k][23:16], VEC[k][15:8]);
            read_at(1'b0, 8'h88, rd);
            chk($sformatf("R2 R3 R4 vec%0d", k), rd, VEC[k][7:0]);
        end

        // R4 decode of neighbours
        bus_addr = 8'h8B; bus_bit_mode = 1'b0; #1;
        chk("R4 hit", {7'b0, bus_hit}, 8'h00);
        chk("R4 rdata", bus_rdata, 8'h00);
        bus_addr = 8'h8D; bus_bit_mode = 1'b1; #1;
        chk("R3 bit hit", {7'b0, bus_hit}, 8'h01);
        bus_addr = 8'h88; bus_bit_mode = 1'b0;
        tick(1);

        // R7 run enable, R3 bit read
        bus_write(1'b1, 8'h8C, 8'h01);
        chk("R7 run", {6'b0, timer_run}, 8'h01);
        read_at(1'b1, 8'h8C, rd);
        chk("R3 bit read", rd, 8'h01);

        // R5 overflow set
        tmr_ovf = 2'b01; tick(1); tmr_ovf = 2'b00;
        chk("R5 set", {6'b0, timer_irq_req}, 8'h01);
        // R6 clear, other channel untouched
        tmr_ack = 2'b10; tick(1); tmr_ack = 2'b00;
        chk("R6 other", {6'b0, timer_irq_req}, 8'h01);
        tmr_ack = 2'b01; tick(1); tmr_ack = 2'b00;
        chk("R6 clear", {6'b0, timer_irq_req}, 8'h00);

        // R5 priority over ack and write
        tmr_ovf = 2'b10; tmr_ack = 2'b10;
        bus_write(1'b0, 8'h88, 8'h00);
        tmr_ovf = 2'b00; tmr_ack = 2'b00;
        read_at(1'b0, 8'h88, rd);
        chk("R5 priority", rd, 8'h80);
        chk("R7 stop", {6'b0, timer_run}, 8'h00);
        tmr_ack = 2'b10; tick(1); tmr_ack = 2'b00;

        // R11 software set and clear of a flag
        bus_write(1'b1, 8'h8D, 8'h01);
        chk("R11 set", {6'b0, timer_irq_req}, 8'h01);
        bus_write(1'b1, 8'h8D, 8'h00);
        chk("R11 clear", {6'b0, timer_irq_req}, 8'h00);

        // R8 edge detect on pin 0
        bus_write(1'b1, 8'h88, 8'h01);
        ext_pin_n[0] = 1'b0;
        tick(2);
        chk("R8 early", {6'b0, ext_irq_req}, 8'h00);
        tick(1);
        chk("R8 set", {6'b0, ext_irq_req}, 8'h01);
        // R9 ack clears
        ext_ack = 2'b01; tick(1); ext_ack = 2'b00;
        chk("R9 clear", {6'b0, ext_irq_req}, 8'h00);
        tick(4);
        chk("R8 steady low", {6'b0, ext_irq_req}, 8'h00);
        ext_pin_n[0] = 1'b1;
        tick(4);
        chk("R8 rising", {6'b0, ext_irq_req}, 8'h00);

        // R9 edge wins over same-cycle ack
        ext_pin_n[0] = 1'b0;
        tick(2);
        ext_ack = 2'b01; tick(1); ext_ack = 2'b00;
        chk("R9 race", {6'b0, ext_irq_req}, 8'h01);
        ext_ack = 2'b01; tick(1); ext_ack = 2'b00;
        ext_pin_n[0] = 1'b1;
        tick(4);

        // R10 level mode on pin 1
        ext_pin_n[1] = 1'b0;
        tick(2);
        chk("R10 early", {6'b0, ext_irq_req}, 8'h00);
        tick(1);
        chk("R10 follow", {6'b0, ext_irq_req}, 8'h02);
        ext_ack = 2'b10; tick(1); ext_ack = 2'b00;
        chk("R10 ack", {6'b0, ext_irq_req}, 8'h02);
        bus_write(1'b1, 8'h8B, 8'h00);
        read_at(1'b1, 8'h8B, rd);
        chk("R10 write", rd, 8'h01);
        ext_pin_n[1] = 1'b1;
        tick(2);
        chk("R10 lag", {6'b0, ext_irq_req}, 8'h02);
        tick(1);
        chk("R10 release", {6'b0, ext_irq_req}, 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule